// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses of one memory burst, one address per clock cycle. A controller pulses a start strobe with a starting column, a three-bit burst length code, a wrap-order bit, a transfer-direction bit and a single-write option. From the following cycle the block presents the burst's columns in order, together with a valid flag and a flag that marks the final beat.

Fixed-length bursts of 1, 2, 4 or 8 beats stay inside the aligned block that contains the starting column. Their order is either a linear count that wraps within that block or an XOR of the start with a beat counter. A full-page burst walks the whole 10-bit column space and wraps at the end. It keeps running until a stop strobe arrives.

The controller may cut any burst short with a stop strobe. It may also restart the block with a new column on any cycle, which abandons the burst in progress. The block is a three-state machine:
- **IDLE**: no beat is issued.
- **FIXED**: a burst of fixed length is running.
- **PAGE**: a full-page burst is running.

The transitions are:
- *launch*: any state goes to FIXED or PAGE when start is high.
- *halt*: FIXED or PAGE goes to IDLE when stop is high.
- *complete*: FIXED goes to IDLE after the final beat.
- *advance*: FIXED or PAGE stays put and steps the beat counter.

Top module: `burst_colgen`

## Requirements
- R1: While reset is held and in the first cycle after it is released with no start, valid_o and last_o are 0.
- R2: In the cycle after start_i is sampled high, valid_o is 1 and col_o equals the start_col_i value sampled with it.
- R3: The length code bl_code_i selects the burst length: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives full page. Codes 3'b100, 3'b101 and 3'b110 give length 1.
- R4: With interleave_i = 0 and length L, beat i has col_o = {start bits above log2(L), (start + i) mod L}.
- R5: With interleave_i = 1 and a fixed length L, beat i has col_o = start XOR i, which changes only the low log2(L) bits.
- R6: A full-page burst gives col_o = (start + i) mod 1024 on beat i and ignores interleave_i. It never asserts last_o and continues until it is stopped or restarted.
- R7: In a fixed-length burst, last_o is 1 on the final beat only, and valid_o is 0 in the following cycle unless start_i was high.
- R8: When stop_i is sampled high without start_i, valid_o is 0 in the next cycle.
- R9: When single_write_i = 1 and is_write_i = 1, the burst has length 1 whatever bl_code_i says. Reads keep the programmed length.
- R10: start_i sampled high during a burst aborts that burst and restarts at the new column. start_i has priority over a stop_i sampled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a burst at start_col_i |
| start_col_i | input | 10 | Starting column |
| bl_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 1 = XOR order, 0 = linear order |
| is_write_i | input | 1 | The burst is a write |
| single_write_i | input | 1 | Force writes to a length of one |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | 10 | Column address of the current beat |
| valid_o | output | 1 | col_o holds a burst beat |
| last_o | output | 1 | Current beat is the final one of a fixed burst |

## Verification
Two functions can act in the same cycle: a stop request and a new start. The second collision is a start on the very beat that carries last_o. The bench drives both collisions on purpose, and random traffic also produces them at a steady rate. In each case the expected result is a fresh burst: its first beat appears at the new column with valid_o held high, and no idle gap appears. The bench model predicts this independently from R10.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIXED,
        ST_PAGE
    } bst_e;

    localparam logic [2:0] BLC_ONE   = 3'b000;
    localparam logic [2:0] BLC_TWO   = 3'b001;
    localparam logic [2:0] BLC_FOUR  = 3'b010;
    localparam logic [2:0] BLC_EIGHT = 3'b011;
    localparam logic [2:0] BLC_PAGE  = 3'b111;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
    import burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [2:0]       bl_code_i,
    input  logic             is_write_i,
    input  logic             single_write_i,
    output logic [COL_W-1:0] mask_o,
    output logic             page_o
);
    always_comb begin
        mask_o = '0;
        page_o = 1'b0;
        if (!(single_write_i && is_write_i)) begin
            unique case (bl_code_i)
                BLC_TWO:   mask_o = COL_W'(1);
                BLC_FOUR:  mask_o = COL_W'(3);
                BLC_EIGHT: mask_o = COL_W'(7);
                BLC_PAGE: begin
                    mask_o = '1;
                    page_o = 1'b1;
                end
                default:   mask_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] cnt_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] lin_sum;

    always_comb begin
        lin_sum = base_i + cnt_i;
        if (ilv_i)
            col_o = base_i ^ (cnt_i & mask_i);
        else
            col_o = (base_i & ~mask_i) | (lin_sum & mask_i);
    end
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
    import burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       bl_code_i,
    input  logic             interleave_i,
    input  logic             is_write_i,
    input  logic             single_write_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);
    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    bst_e             state_q, state_d;
    logic [COL_W-1:0] base_q, cnt_q, mask_q;
    logic             ilv_q;
    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic [COL_W-1:0] calc_col;

    burst_len_decode #(.COL_W(COL_W)) u_dec (
        .bl_code_i      (bl_code_i),
        .is_write_i     (is_write_i),
        .single_write_i (single_write_i),
        .mask_o         (dec_mask),
        .page_o         (dec_page)
    );

    burst_addr_calc #(.COL_W(COL_W)) u_calc (
        .base_i (base_q),
        .cnt_i  (cnt_q),
        .mask_i (mask_q),
        .ilv_i  (ilv_q),
        .col_o  (calc_col)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = dec_page ? ST_PAGE : ST_FIXED;          // launch
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_FIXED: begin
                    if (stop_i)               state_d = ST_IDLE;  // halt
                    else if (cnt_q == mask_q) state_d = ST_IDLE;  // complete
                    else                      state_d = ST_FIXED; // advance
                end
                ST_PAGE:  state_d = stop_i ? ST_IDLE : ST_PAGE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register and burst context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            cnt_q   <= '0;
            mask_q  <= '0;
            ilv_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_i) begin
                base_q <= start_col_i;
                cnt_q  <= '0;
                mask_q <= dec_mask;
                ilv_q  <= interleave_i && !dec_page;
            end else if (state_q != ST_IDLE) begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

    // outputs
    always_comb begin
        col_o   = '0;
        valid_o = 1'b0;
        last_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FIXED: begin
                col_o   = calc_col;
                valid_o = 1'b1;
                last_o  = (cnt_q == mask_q);
            end
            ST_PAGE: begin
                col_o   = calc_col;
                valid_o = 1'b1;
            end
            default: ;
        endcase
    end

    AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i)));           // R2
    AST_STOP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !valid_o);                              // R8
    AST_LAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && last_o && !start_i) |=> !valid_o);                   // R7
    AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE) |-> !last_o);                               // R6
    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE && !start_i && !stop_i)
        |=> (valid_o && col_o == ($past(col_o) + ONE)));                 // R6
    AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);                                             // R7
endmodule

// File: tb/sim_burst_colgen.sv
`timescale 1ns/1ps
module sim_burst_colgen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [9:0] start_col_i = '0;
    logic [2:0] bl_code_i = '0;
    logic       interleave_i = 1'b0;
    logic       is_write_i = 1'b0;
    logic       single_write_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [9:0] col_o;
    logic       valid_o, last_o;

    int n_vec = 0;
    int n_bad = 0;

    // reference state
    bit         m_act = 0;
    bit         m_page = 0;
    bit         m_ilv = 0;
    logic [9:0] m_base = '0;
    int         m_idx = 0;
    int         m_len = 1;

    always #2.5 clk = ~clk;

    burst_colgen u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .bl_code_i(bl_code_i), .interleave_i(interleave_i), .is_write_i(is_write_i),
        .single_write_i(single_write_i), .stop_i(stop_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    function automatic int code_len(logic [2:0] c, bit wr, bit sw);
        if (wr && sw) return 1;               // R9
        case (c)                              // R3
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            3'b111: return 0;                 // 0 marks full page
            default: return 1;
        endcase
    endfunction

    function automatic logic [9:0] ref_col(logic [9:0] b, int i, int len, bit pg, bit ilv);
        logic [9:0] m;
        logic [9:0] iv;
        iv = 10'(i);
        if (pg) return b + iv;                // R6
        m = 10'(len - 1);
        if (ilv) return b ^ (iv & m);         // R5
        return (b & ~m) | ((b + iv) & m);     // R4
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [9:0] ec;
        bit el;
        check(valid_o == m_act, m_act ? "R7" : "R8", int'(valid_o), int'(m_act));
        if (m_act && valid_o) begin
            ec = ref_col(m_base, m_idx, m_len, m_page, m_ilv);
            el = !m_page && (m_idx == m_len - 1);
            check(col_o == ec, m_page ? "R6" : (m_ilv ? "R5" : "R4"), int'(col_o), int'(ec));
            check(last_o == el, m_page ? "R6" : "R7", int'(last_o), int'(el));
        end
    endtask

    task automatic model_step();
        if (start_i) begin                    // R10: start first
            m_act  = 1;
            m_base = start_col_i;
            m_idx  = 0;
            m_len  = code_len(bl_code_i, is_write_i, single_write_i);
            m_page = (m_len == 0);
            m_ilv  = interleave_i && !m_page;
        end else if (m_act) begin
            if (stop_i) m_act = 0;
            else if (!m_page && m_idx == m_len - 1) m_act = 0;
            else m_idx = (m_idx + 1) % 1024;
        end
    endtask

    task automatic cyc(bit st, logic [9:0] col, logic [2:0] code, bit ilv, bit wr, bit sw, bit sp);
        start_i = st; start_col_i = col; bl_code_i = code; interleave_i = ilv;
        is_write_i = wr; single_write_i = sw; stop_i = sp;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc(0, '0, 3'b000, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!valid_o && !last_o, "R1", int'({valid_o, last_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        compare();                                   // R1 after release
        cyc(1, 10'h02D, 3'b011, 0, 0, 0, 0); idle(9); // R2 R4 R7: 8 linear beats
        cyc(1, 10'h02D, 3'b011, 1, 0, 0, 0); idle(9); // R5 xor order
        cyc(1, 10'h017, 3'b010, 0, 0, 0, 0); idle(5); // R4 length 4
        cyc(1, 10'h3FD, 3'b111, 1, 0, 0, 0); idle(6); // R6 wrap past 3FF, ilv ignored
        cyc(0, '0, 3'b000, 0, 0, 0, 1); idle(2);      // R8 stop page
        cyc(1, 10'h055, 3'b101, 0, 0, 0, 0); idle(2); // R3 reserved code -> 1
        cyc(1, 10'h0A2, 3'b011, 0, 1, 1, 0); idle(2); // R9 write forced to 1
        cyc(1, 10'h0A2, 3'b011, 0, 0, 1, 0); idle(9); // R9 read keeps 8
        cyc(1, 10'h100, 3'b011, 0, 0, 0, 0); idle(2);
        cyc(1, 10'h207, 3'b001, 0, 0, 0, 1); idle(3); // R10 start beats stop
        cyc(1, 10'h300, 3'b001, 0, 0, 0, 0); idle(1);
        cyc(1, 10'h111, 3'b000, 0, 0, 0, 0); idle(2); // R10 start on last beat
        for (int k = 0; k < 4000; k++) begin
            bit st, sp;
            st = ($urandom_range(0, m_act ? 19 : 5) == 0);
            sp = ($urandom_range(0, 24) == 0);
            cyc(st, 10'($urandom_range(0, 1023)), 3'($urandom_range(0, 7)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), sp);
        end
        summary();
        $finish;
    end
endmodule